// File: doc/BRIEF.md
# Time-Stamp Event Capture Unit

This block keeps a free-running 32-bit time counter that advances by one on every cycle of a 125 MHz clock, so one count is 8 ns and the counter wraps after roughly 34.4 seconds. Beside the counter sits a single capture channel. When the selected event occurs, the channel stores the counter value. The event is either an edge on an asynchronous external event-request input or a one-cycle pulse-per-second strobe from elsewhere on the chip.

Software uses the block through a small 16-bit register port. It sets up edge polarity, overwrite behaviour and event counting in a configuration register. It picks the event source and watches valid and missed-event flags in a status register. It reads the stored stamp as two 16-bit words. After taking a stamp, software writes the status register to clear the valid flag and so re-arm the channel. Any write to the status register also clears the 8-bit capture sequence counter.

The reset input is active low and asynchronous. Its deassertion must already be synchronous to `clk`.

Top module: `tsc_capture_unit`

## Requirements
- R1: The time counter is 32 bits wide and reads 0 right after reset. It increases by one on every clock edge after that and wraps from all ones to zero.
- R2: Register addresses are: 0 configuration, 1 status, 2 stamp bits 15:0, 3 stamp bits 31:16, 4 time bits 15:0, 5 time bits 31:16. A read strobe at address 4 copies time bits 31:16 into a shadow at that same edge. Address 5 returns the shadow, so a low-then-high read pair stays consistent across a carry from the low half into the high half.
- R3: Configuration bits: bit 0 selects the falling edge of the external input (0 selects rising), bit 1 enables overwrite, bit 2 starts the sequence counter. All 16 bits read back as last written.
- R4: The external input passes through a two-flop synchronizer. A change that the first flop samples at edge k yields a stamp equal to the counter value held just before edge k+2.
- R5: Only the configured edge polarity of the external input causes a capture. The opposite edge leaves status and stamp unchanged.
- R6: Status bit 2 selects the source: 1 selects the pulse-per-second strobe, 0 selects the external input. A strobe sampled high at an edge captures the counter value held just before that edge. Activity on the source that is not selected has no effect.
- R7: An event while the valid flag (status bit 0) is clear loads the stamp and sets the valid flag.
- R8: An event while the valid flag is set sets the error flag (status bit 1). With overwrite disabled, the held stamp is kept.
- R9: With overwrite enabled, an event while the valid flag is set replaces the stamp, keeps the valid flag set and still sets the error flag.
- R10: A status write clears bit 0 or bit 1 when the written bit is 0 and leaves that flag alone when the written bit is 1. The write stores bit 2 and bits 7:3 (the latter read back as written) and resets the sequence counter (status bits 15:8) to 0. An event in the same cycle as a status write is dropped.
- R11: The sequence counter counts each accepted event (one that loads the stamp) while configuration bit 2 is set. It does not count while that bit is clear, and it saturates at 255.
- R12: After reset, configuration, status, stamp and shadow all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz clock, one count per cycle |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| evt_req_in | input | 1 | Asynchronous external event-request input |
| pps_strobe | input | 1 | Synchronous one-cycle pulse-per-second strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for the time snapshot) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |

## Verification
Every stamp is predicted from a cycle model of the counter, so a synchronizer stage added or dropped shows up as an error of one or two counts in the first stamp read back. If the valid, error or overwrite logic is wrong, the fault appears at the first back-to-back event: the status word gets the wrong flags, or the stamp words change when they should not (or stay the same when they should change). A sequence counter that wraps instead of saturating, or a shadow loaded at the wrong time, is exposed after a few hundred strobes and at the first carry out of the low time word.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG    = 3'd0,
    A_STATUS = 3'd1,
    A_CAP_LO = 3'd2,
    A_CAP_HI = 3'd3,
    A_TIM_LO = 3'd4,
    A_TIM_HI = 3'd5
  } tsc_addr_e;

  // configuration bit positions
  localparam int CFG_FALLING  = 0;
  localparam int CFG_OVERWR   = 1;
  localparam int CFG_CNT_RUN  = 2;

  // status bit positions
  localparam int ST_VALID     = 0;
  localparam int ST_ERROR     = 1;
  localparam int ST_SRC_PPS   = 2;
  localparam int ST_RSV_LO    = 3;
  localparam int ST_RSV_HI    = 7;
  localparam int ST_SEQ_LO    = 8;
endpackage

// File: rtl/tsc_timebase.sv
module tsc_timebase #(
  parameter int TW = 32,
  parameter int RW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_en,
  output logic [TW-1:0]    time_o,
  output logic [TW-RW-1:0] shadow_o
);
  localparam int HW = TW - RW;

  logic [TW-1:0] time_q, time_d;
  logic [HW-1:0] shadow_q, shadow_d;

  always_comb begin
    time_d   = time_q + TW'(1);
    shadow_d = shadow_q;
    if (snap_en) shadow_d = time_q[TW-1:RW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      shadow_q <= '0;
    end else begin
      time_q <= time_d;
      if (snap_en) shadow_q <= shadow_d;
    end
  end

  assign time_o   = time_q;
  assign shadow_o = shadow_q;

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> time_q == ($past(time_q) + TW'(1))); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(shadow_q)); // R2
endmodule

// File: rtl/tsc_event_detect.sv
module tsc_event_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  input  logic falling,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= evt_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_comb begin
    if (falling) edge_o = prev_q & ~cur;
    else         edge_o = ~prev_q & cur;
  end

  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(falling)) |=> !edge_o); // R5
endmodule

// File: rtl/tsc_capture_ch.sv
module tsc_capture_ch #(
  parameter int TW    = 32,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [TW-1:0]    stamp_in,
  input  logic             overwrite,
  input  logic             count_on,
  input  logic             stat_wr,
  input  logic             keep_valid,
  input  logic             keep_err,
  output logic             valid_o,
  output logic             err_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [TW-1:0]    stamp_o
);
  localparam logic [SEQ_W-1:0] SEQ_MAX = '1;

  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [TW-1:0]    stamp_q, stamp_d;
  logic             accept;

  assign accept = evt && !stat_wr && (!valid_q || overwrite);

  always_comb begin
    valid_d = valid_q;
    err_d   = err_q;
    seq_d   = seq_q;
    stamp_d = stamp_q;
    if (stat_wr) begin
      valid_d = valid_q & keep_valid;
      err_d   = err_q & keep_err;
      seq_d   = '0;
    end else if (evt) begin
      if (valid_q) err_d = 1'b1;
      if (accept) begin
        stamp_d = stamp_in;
        valid_d = 1'b1;
        if (count_on && (seq_q != SEQ_MAX)) seq_d = seq_q + SEQ_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      seq_q   <= '0;
      stamp_q <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      seq_q   <= seq_d;
      if (accept) stamp_q <= stamp_d;
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign seq_o   = seq_q;
  assign stamp_o = stamp_q;

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !valid_q && !stat_wr) |=> (valid_q && stamp_q == $past(stamp_in))); // R7

  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && valid_q && !stat_wr) |=> err_q); // R8

  AST_KEEP_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && valid_q && !overwrite && !stat_wr) |=> $stable(stamp_q)); // R8

  AST_OVERWRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && valid_q && overwrite && !stat_wr) |=> (valid_q && stamp_q == $past(stamp_in))); // R9

  AST_SEQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> seq_q == '0); // R10

  AST_SEQ_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SEQ_MAX && !stat_wr) |=> seq_q == SEQ_MAX); // R11

  AST_SEQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_on && !stat_wr) |=> $stable(seq_q)); // R11
endmodule

// File: rtl/tsc_capture_unit.sv
module tsc_capture_unit
  import tsc_pkg::*;
#(
  parameter int TW          = 32,
  parameter int SEQ_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_req_in,
  input  logic              pps_strobe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int HW    = TW - REG_W;
  localparam int RSV_W = ST_RSV_HI - ST_RSV_LO + 1;

  logic [REG_W-1:0] cfg_q, cfg_d;
  logic             src_pps_q, src_pps_d;
  logic [RSV_W-1:0] rsv_q, rsv_d;
  logic             cfg_wr, stat_wr, snap_en;

  logic [TW-1:0]    time_now;
  logic [HW-1:0]    time_shadow;
  logic             ext_edge;
  logic             evt_sel;
  logic             cap_valid, cap_err;
  logic [SEQ_W-1:0] cap_seq;
  logic [TW-1:0]    cap_stamp;

  assign cfg_wr  = reg_wr && (reg_addr == A_CFG);
  assign stat_wr = reg_wr && (reg_addr == A_STATUS);
  assign snap_en = reg_rd && (reg_addr == A_TIM_LO);

  always_comb begin
    cfg_d     = cfg_q;
    src_pps_d = src_pps_q;
    rsv_d     = rsv_q;
    if (cfg_wr) cfg_d = reg_wdata;
    if (stat_wr) begin
      src_pps_d = reg_wdata[ST_SRC_PPS];
      rsv_d     = reg_wdata[ST_RSV_HI:ST_RSV_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      src_pps_q <= 1'b0;
      rsv_q     <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_d;
      if (stat_wr) begin
        src_pps_q <= src_pps_d;
        rsv_q     <= rsv_d;
      end
    end
  end

  tsc_timebase #(.TW(TW), .RW(REG_W)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .snap_en  (snap_en),
    .time_o   (time_now),
    .shadow_o (time_shadow)
  );

  tsc_event_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_async (evt_req_in),
    .falling   (cfg_q[CFG_FALLING]),
    .edge_o    (ext_edge)
  );

  assign evt_sel = src_pps_q ? pps_strobe : ext_edge;

  tsc_capture_ch #(.TW(TW), .SEQ_W(SEQ_W)) u_channel (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_sel),
    .stamp_in   (time_now),
    .overwrite  (cfg_q[CFG_OVERWR]),
    .count_on   (cfg_q[CFG_CNT_RUN]),
    .stat_wr    (stat_wr),
    .keep_valid (reg_wdata[ST_VALID]),
    .keep_err   (reg_wdata[ST_ERROR]),
    .valid_o    (cap_valid),
    .err_o      (cap_err),
    .seq_o      (cap_seq),
    .stamp_o    (cap_stamp)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CFG:    reg_rdata = cfg_q;
      A_STATUS: begin
        reg_rdata[ST_VALID]            = cap_valid;
        reg_rdata[ST_ERROR]            = cap_err;
        reg_rdata[ST_SRC_PPS]          = src_pps_q;
        reg_rdata[ST_RSV_HI:ST_RSV_LO] = rsv_q;
        reg_rdata[ST_SEQ_LO +: SEQ_W]  = cap_seq;
      end
      A_CAP_LO: reg_rdata = cap_stamp[REG_W-1:0];
      A_CAP_HI: reg_rdata = cap_stamp[TW-1:REG_W];
      A_TIM_LO: reg_rdata = time_now[REG_W-1:0];
      A_TIM_HI: reg_rdata = time_shadow;
      default:  reg_rdata = '0;
    endcase
  end

  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_pps_q && !ext_edge && !reg_wr) |=> ($stable(cap_stamp) && $stable(cap_seq))); // R6

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q)); // R3
endmodule

// File: tb/tsc_capture_unit_tb.sv
module tsc_capture_unit_tb;
  localparam int CLK_PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_req_in = 1'b0;
  logic        pps_strobe = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;

  int          n_tests = 0;
  int          n_fail = 0;
  logic [31:0] cyc = 32'd0;     // model of the time counter
  logic [31:0] exp_q[$];        // scoreboard of expected stamps
  logic [31:0] held;
  bit          done = 1'b0;

  tsc_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_req_in(evt_req_in), .pps_strobe(pps_strobe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 32'd1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: external level change, pushes expected stamp when a capture is due
  task automatic ext_drive(input logic v, input bit push);
    @(negedge clk);
    evt_req_in = v;
    if (push) exp_q.push_back(cyc + 32'd2);
    idle(5);
  endtask

  task automatic pps_drive(input bit push);
    @(negedge clk);
    pps_strobe = 1'b1;
    if (push) exp_q.push_back(cyc);
    @(negedge clk);
    pps_strobe = 1'b0;
  endtask

  // monitor side: pops the oldest expected stamp and compares both words
  task automatic stamp_chk(input string req);
    logic [15:0] lo, hi;
    logic [31:0] e;
    if (exp_q.size() == 0) begin
      chk({req, " queue empty"}, 32'd1, 32'd0);
      return;
    end
    e = exp_q.pop_front();
    rd(3'd2, lo);
    rd(3'd3, hi);
    chk(req, {hi, lo}, e);
    held = e;
  endtask

  task automatic held_chk(input string req);
    logic [15:0] lo, hi;
    rd(3'd2, lo);
    rd(3'd3, hi);
    chk(req, {hi, lo}, held);
  endtask

  task automatic stat_chk(input string req, input logic [15:0] e);
    logic [15:0] d;
    rd(3'd1, d);
    chk(req, {16'd0, d}, {16'd0, e});
  endtask

  initial begin
    logic [15:0] d;
    logic [31:0] snap;
    held = 32'd0;
    idle(3);
    rst_n = 1'b1;

    // R12: reset state
    rd(3'd0, d); chk("R12 config", {16'd0, d}, 32'd0);
    stat_chk("R12 status", 16'h0000);
    held_chk("R12 stamp");
    rd(3'd5, d); chk("R12 shadow", {16'd0, d}, 32'd0);

    // R1: counter runs from reset
    @(negedge clk); reg_addr = 3'd4; reg_rd = 1'b1;
    #1 chk("R1 time low", {16'd0, reg_rdata}, {16'd0, cyc[15:0]});
    @(negedge clk); reg_rd = 1'b0;

    // R3: config readback incl. upper bits
    wr(3'd0, 16'hA504);
    rd(3'd0, d); chk("R3 config readback", {16'd0, d}, 32'h0000A504);

    // R4 R7 R11: rising edge capture
    ext_drive(1'b1, 1'b1);
    stat_chk("R7 R11 valid seq1", 16'h0101);
    stamp_chk("R4 stamp two-stage sync");

    // R5: falling edge ignored while rising selected
    ext_drive(1'b0, 1'b0);
    stat_chk("R5 opposite edge no status change", 16'h0101);
    held_chk("R5 opposite edge keeps stamp");

    // R8: missed event, overwrite off
    ext_drive(1'b1, 1'b0);
    stat_chk("R8 error set seq held", 16'h0103);
    held_chk("R8 stamp kept");

    // R10: clear everything
    wr(3'd1, 16'h0000);
    stat_chk("R10 clear flags and seq", 16'h0000);

    // R5: falling polarity
    wr(3'd0, 16'h0005);
    ext_drive(1'b0, 1'b1);
    stat_chk("R5 falling capture", 16'h0101);
    stamp_chk("R5 falling stamp");

    // R9: overwrite, rising ignored first
    wr(3'd0, 16'h0007);
    ext_drive(1'b1, 1'b0);
    stat_chk("R5 rising ignored in falling mode", 16'h0101);
    ext_drive(1'b0, 1'b1);
    stat_chk("R9 overwrite error seq2", 16'h0203);
    stamp_chk("R9 stamp replaced");

    // R10: write 1 keeps valid, 0 clears error, reserved bits stored
    wr(3'd1, 16'h0029);
    stat_chk("R10 keep valid clear error", 16'h0029);

    // R6: pps source, external ignored
    wr(3'd1, 16'h0004);
    ext_drive(1'b1, 1'b0);
    ext_drive(1'b0, 1'b0);
    stat_chk("R6 external ignored when pps selected", 16'h0004);
    pps_drive(1'b1);
    idle(2);
    stat_chk("R6 pps capture", 16'h0105);
    stamp_chk("R6 pps stamp");

    // R11: counting stopped
    wr(3'd0, 16'h0002);
    pps_drive(1'b1);
    idle(2);
    stat_chk("R11 no count when stopped", 16'h0107);
    stamp_chk("R9 pps overwrite stamp");

    // R11: saturation
    wr(3'd0, 16'h0006);
    wr(3'd1, 16'h0004);
    for (int i = 0; i < 260; i++) pps_drive(1'b0);
    idle(2);
    stat_chk("R11 saturates at 255", 16'hFF07);

    // R2: shadow consistency across low-word carry
    while (cyc[15:0] != 16'hFFFE) @(negedge clk);
    @(negedge clk);
    reg_addr = 3'd4; reg_rd = 1'b1;
    #1 snap = cyc;
    chk("R2 time low at carry", {16'd0, reg_rdata}, {16'd0, snap[15:0]});
    @(negedge clk); reg_rd = 1'b0;
    rd(3'd5, d);
    chk("R2 shadow high consistent", {16'd0, d}, {16'd0, snap[31:16]});
    rd(3'd4, d);
    rd(3'd5, d);
    chk("R1 high word after carry", {16'd0, d}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule